// File: doc/BRIEF.md
# Multi-Mode Ripple Arithmetic Slice

This block is a 4-bit arithmetic slice built around one ripple carry chain. A chain-level wrapper joins several slices into a wider datapath. A two-bit mode code gives the shared chain one of three jobs.

- **Counter:** the chain acts as an incrementer or a decrementer of the present count.
- **Multiply step:** the chain acts as a conditional adder. It forms one step of a shift-and-add multiplier, adding the multiplicand to a partial product or passing the partial product on.
- **Comparator:** the chain acts as a cascadable mismatch detector.

Each slice has four flip-flops that capture the combinational result. In counter use, the registered value is driven back onto the operand input, so the flip-flops hold the present count.

The wrapper gives the control bit to every slice: the count direction in counter mode, the multiplier bit in multiply mode. Each slice's carry-out drives the next slice's carry-in. In comparator mode the wrapper forces the carry into the lowest slice to 0.

Top module: `ras_chain`

## Requirements
- R1: Mode code 00 with ctl_i=1 counts up: f_o = a_i + cin_i modulo 2^W. cout_o is 1 only when cin_i=1 and a_i is all ones.
- R2: Mode code 00 with ctl_i=0 counts down: f_o = a_i - cin_i modulo 2^W. cout_o is 1 only when cin_i=1 and a_i is zero.
- R3: A counter made from chained slices wraps across its full width. With cin_i=1 and q_o fed back to a_i, a count of 0 steps down to all ones, and all ones steps up to 0.
- R4: Mode code 01 with ctl_i=1 gives {cout_o, f_o} = a_i + b_i + cin_i.
- R5: Mode code 01 with ctl_i=0 gives {cout_o, f_o} = a_i + cin_i, so the partial product passes through unchanged when cin_i=0.
- R6: Mode code 10 gives cout_o = 1 exactly when a_i differs from b_i in any bit. cin_i has no effect, because the carry into the lowest slice is forced to 0.
- R7: Mode code 10 gives f_o = a_i XOR b_i, which flags the mismatching bits.
- R8: On each rising clock edge with rst=0 and ce=1, q_o takes the value f_o had before the edge. With ce=0, q_o holds its value.
- R9: A rising edge with rst=1 clears q_o to zero, whatever ce is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the result registers |
| ce | input | 1 | Clock enable of the result registers |
| mode_i | input | 2 | 00 counter, 01 multiply step, 10 comparator, 11 reserved (f_o = a_i, cout_o = 0) |
| a_i | input | W | Present count, partial product, or first comparator operand |
| ctl_i | input | 1 | Count direction (1 = up) or multiplier bit, sent to every slice |
| b_i | input | W | Multiplicand or second comparator operand |
| cin_i | input | 1 | Carry into the lowest slice |
| f_o | output | W | Combinational result |
| q_o | output | W | Registered result |
| cout_o | output | 1 | Carry-out of the highest slice |

## Verification
The bench builds the chain with its default of four slices, which gives a 16-bit width. At that width a carry has to ripple through three slice boundaries, and the all-ones and all-zeros wrap points need the terminal-count carry to pass through every slice. A 16-bit counter run with feedback reaches both wrap points within a few cycles. Random multiply-step and comparator operands, mixed with forced equal pairs, exercise carries and mismatches that start in any slice.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam int SLICE_W = 4;

  typedef enum logic [1:0] {
    M_COUNT = 2'b00,
    M_MAC   = 2'b01,
    M_EQ    = 2'b10,
    M_RSVD  = 2'b11
  } mode_t;

  typedef struct packed {
    logic [SLICE_W-1:0] p;
    logic [SLICE_W-1:0] g;
    logic               inv;
  } pg_t;

  // Propagate/generate terms that turn the shared chain into each function.
  function automatic pg_t select_pg(mode_t m, logic [SLICE_W-1:0] a,
                                    logic ctl, logic [SLICE_W-1:0] b);
    pg_t r;
    logic [SLICE_W-1:0] y;
    r = '0;
    case (m)
      M_COUNT: begin
        // down count: invert, increment, invert back
        r.p   = ctl ? a : ~a;
        r.g   = '0;
        r.inv = ~ctl;
      end
      M_MAC: begin
        y   = ctl ? b : '0;
        r.p = a ^ y;
        r.g = a & y;
      end
      M_EQ: begin
        // each mismatching bit generates, every bit propagates
        r.p = '1;
        r.g = a ^ b;
      end
      default: begin
        r.p = a;
        r.g = '0;
      end
    endcase
    return r;
  endfunction

  function automatic logic [SLICE_W-1:0] shape_result(mode_t m,
      logic [SLICE_W-1:0] a, logic [SLICE_W-1:0] b, logic inv,
      logic [SLICE_W-1:0] sum);
    case (m)
      M_COUNT: return inv ? ~sum : sum;
      M_MAC:   return sum;
      M_EQ:    return a ^ b;
      default: return a;
    endcase
  endfunction
endpackage

// File: rtl/ras_carry.sv
module ras_carry #(
  parameter int W = 4
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] g,
  input  logic         cin,
  output logic [W:0]   c
);
  assign c[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign c[i+1] = g[i] | (p[i] & c[i]);
  end
endmodule

// File: rtl/ras_qreg.sv
module ras_qreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ce) q <= d;
  end

  // R8
  load_chk: assert property (@(posedge clk) disable iff (rst)
    ce |=> (q == $past(d)));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(q));
  // R9
  reset_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));
endmodule

// File: rtl/ras_slice.sv
module ras_slice
  import ras_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ce,
  input  mode_t              mode,
  input  logic [SLICE_W-1:0] a,
  input  logic               ctl,
  input  logic [SLICE_W-1:0] b,
  input  logic               cin,
  output logic [SLICE_W-1:0] f,
  output logic [SLICE_W-1:0] q,
  output logic               cout
);
  pg_t                sel;
  logic [SLICE_W:0]   carry;
  logic [SLICE_W-1:0] sum;
  logic               terminal_up;
  logic               terminal_dn;

  assign sel = select_pg(mode, a, ctl, b);

  ras_carry #(.W(SLICE_W)) u_chain (
    .p   (sel.p),
    .g   (sel.g),
    .cin (cin),
    .c   (carry)
  );

  assign sum  = sel.p ^ carry[SLICE_W-1:0];
  assign f    = shape_result(mode, a, b, sel.inv, sum);
  assign cout = (mode == M_RSVD) ? 1'b0 : carry[SLICE_W];

  assign terminal_up = (mode == M_COUNT) && ctl  && cin && (a == '1);
  assign terminal_dn = (mode == M_COUNT) && !ctl && cin && (a == '0);

  ras_qreg #(.W(SLICE_W)) u_q (
    .clk (clk),
    .rst (rst),
    .ce  (ce),
    .d   (f),
    .q   (q)
  );

  // R1
  up_terminal_chk: assert property (@(posedge clk) disable iff (rst)
    terminal_up |-> (cout && f == '0));
  // R2
  dn_terminal_chk: assert property (@(posedge clk) disable iff (rst)
    terminal_dn |-> (cout && f == '1));
  // R1 R2
  count_carry_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == M_COUNT) && !terminal_up && !terminal_dn) |-> !cout);
endmodule

// File: rtl/ras_chain.sv
module ras_chain
  import ras_pkg::*;
#(
  parameter int NSLICE = 4,
  localparam int W = NSLICE * SLICE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] a_i,
  input  logic         ctl_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] f_o,
  output logic [W-1:0] q_o,
  output logic         cout_o
);
  mode_t           mode;
  logic [NSLICE:0] link;
  logic            mismatch;

  assign mode    = mode_t'(mode_i);
  // comparator: carry into the lowest slice is tied low
  assign link[0] = (mode == M_EQ) ? 1'b0 : cin_i;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    ras_slice u_slice (
      .clk  (clk),
      .rst  (rst),
      .ce   (ce),
      .mode (mode),
      .a    (a_i[s*SLICE_W +: SLICE_W]),
      .ctl  (ctl_i),
      .b    (b_i[s*SLICE_W +: SLICE_W]),
      .cin  (link[s]),
      .f    (f_o[s*SLICE_W +: SLICE_W]),
      .q    (q_o[s*SLICE_W +: SLICE_W]),
      .cout (link[s+1])
    );
  end

  assign cout_o   = link[NSLICE];
  assign mismatch = |(a_i ^ b_i);

  // R6
  eq_cascade_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_EQ) |-> (cout_o == mismatch));
  // R4
  mac_add_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_MAC && ctl_i) |-> ({cout_o, f_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i))));
  // R5
  mac_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_MAC && !ctl_i && !cin_i) |-> (f_o == a_i && !cout_o));
endmodule

// File: tb/sim_ras_chain.sv
`timescale 1ns/1ps
module sim_ras_chain;
  localparam int NS = 4;
  localparam int W  = NS * 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ce = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] a_man = '0;
  logic         fb = 1'b0;
  logic         ctl = 1'b0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] a_eff;
  logic [W-1:0] f_o, q_o;
  logic         cout_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] q_exp = '0;
  bit done = 0;

  assign a_eff = fb ? q_o : a_man;

  always #5 clk = ~clk;

  ras_chain #(.NSLICE(NS)) u0 (
    .clk(clk), .rst(rst), .ce(ce), .mode_i(mode), .a_i(a_eff),
    .ctl_i(ctl), .b_i(b), .cin_i(cin), .f_o(f_o), .q_o(q_o), .cout_o(cout_o)
  );

  task automatic model(output logic [W-1:0] ef, output logic ec, output string tag);
    longint s;
    case (mode)
      2'b00: begin
        if (ctl) begin
          s = longint'(a_eff) + longint'(cin);
          ec = cin && (a_eff == {W{1'b1}}); tag = "R1";
        end else begin
          s = longint'(a_eff) - longint'(cin);
          ec = cin && (a_eff == '0); tag = "R2";
        end
        ef = s[W-1:0];
      end
      2'b01: begin
        s = longint'(a_eff) + longint'(cin) + (ctl ? longint'(b) : 0);
        ef = s[W-1:0]; ec = s[W]; tag = ctl ? "R4" : "R5";
      end
      2'b10: begin
        ef = a_eff ^ b; ec = (a_eff != b); tag = "R6/R7";
      end
      default: begin ef = a_eff; ec = 1'b0; tag = "RSVD"; end
    endcase
  endtask

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge, inputs already set.
  task automatic step(string qtag);
    logic [W-1:0] ef; logic ec; string tag;
    #1;
    model(ef, ec, tag);
    check(tag, f_o, ef);
    check(tag, {{(W-1){1'b0}}, cout_o}, {{(W-1){1'b0}}, ec});
    check(qtag, q_o, q_exp);
    @(posedge clk);
    if (rst) q_exp = '0;
    else if (ce) q_exp = ef;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    step("R9");
    step("R9");
    rst = 1'b0; ce = 1'b1;
    step("R9");                         // reset state still visible
    // R3: feedback counter, down across zero then up across all-ones
    mode = 2'b00; fb = 1'b1; cin = 1'b1; ctl = 1'b0;
    for (int i = 0; i < 4; i++) step("R3");
    check("R3", q_o, 16'hFFFC);
    ctl = 1'b1;
    for (int i = 0; i < 5; i++) step("R3");
    check("R3", q_o, 16'h0001);
    fb = 1'b0;
    // R1 R2 random counts, with terminal values forced
    for (int i = 0; i < 60; i++) begin
      ctl = $urandom_range(0, 1);
      cin = $urandom_range(0, 1);
      a_man = (i % 5 == 0) ? (ctl ? 16'hFFFF : 16'h0000) : W'($urandom);
      if (i % 10 == 3) a_man = 16'h0FFF;
      step("R8");
    end
    // R4 R5 multiply step
    mode = 2'b01;
    for (int i = 0; i < 80; i++) begin
      ctl = $urandom_range(0, 1);
      cin = $urandom_range(0, 1);
      a_man = W'($urandom); b = W'($urandom);
      if (i % 7 == 0) begin a_man = 16'hFFFF; b = 16'h0001; end
      step("R8");
    end
    // R6 R7 comparator, cin must not matter
    mode = 2'b10;
    for (int i = 0; i < 80; i++) begin
      cin = $urandom_range(0, 1);
      a_man = W'($urandom);
      b = (i % 3 == 0) ? a_man : W'($urandom);
      if (i % 6 == 1) b = a_man ^ (16'h1 << (i % W));
      step("R8");
    end
    // R8 hold with ce low
    mode = 2'b01; ctl = 1'b1; cin = 1'b0;
    a_man = 16'h1234; b = 16'h1111; step("R8");
    ce = 1'b0;
    for (int i = 0; i < 5; i++) begin
      a_man = W'($urandom); step("R8");
    end
    check("R8", q_o, 16'h2345);
    // R9 reset with ce low clears
    rst = 1'b1; step("R9");
    check("R9", q_o, '0);
    rst = 1'b0; ce = 1'b1; step("R9");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule